// File: doc/BRIEF.md
# ULPI PHY-Side Bus Responder

This block acts as the transceiver end of an 8-bit ULPI link. It owns the `dir` and `nxt` signals. While it holds the bus it drives the shared data byte. While the link holds the bus it samples the link's data byte, `stp` and output-enable. Bytes for the link arrive on a valid/ready stream with a last flag. Each one goes onto the bus with `nxt` high. In any cycle where it owns the bus and has no packet byte to offer, the block drives an 8-bit status byte instead, with `nxt` low. That status byte is composed from the session/VBUS inputs and the current receive-event state.

When nothing is left to send, the block passes the bus to the link through a turnaround cycle. While the link owns the bus, `nxt` stays high as a ready. The first non-zero byte opens a transmit packet. The block forwards that packet on a capture stream, with a last flag on the byte that precedes `stp`. A NOOP byte seen while no packet is open ends the link's turn. A byte seen with `stp` high also ends it. In both cases the bus goes back to the PHY side through another turnaround. Bus misuse by the link pulses an error output.

Top module: `ulpi_phy_responder`

## Requirements
- R1: While reset is held, `ulpi_dir` is 1. In the first cycle after reset the block drives a status byte with `ulpi_nxt`=0, `rxs_ready`=0 and `proto_err`=0.
- R2: Status byte layout: bits [1:0] are always 2'b01 (line state J), bits [3:2] carry the VBUS code, bits [5:4] carry the receive-event code, and bits [7:6] are always 0.
- R3: VBUS code: 2'b11 if `st_vbus_valid`. Otherwise 2'b10 if `st_sess_valid`. Otherwise 2'b00 if `st_sess_end`. Otherwise 2'b01.
- R4: Receive-event code: 2'b10 if `st_host_disc`. Otherwise 2'b11 if a receive is active and `st_rx_err` is set. Otherwise 2'b01 if a receive is active. Otherwise 2'b00. A receive is active between an accepted non-last packet byte and the accepted last byte.
- R5: While the PHY side owns the bus outside a turnaround, a valid stream byte is placed on `ulpi_dout` in the same cycle. `ulpi_nxt`=1 and `rxs_ready`=1 in that cycle.
- R6: A gap inside a packet, where `rxs_valid` is 0 while a receive is active, produces a status byte with `ulpi_nxt`=0 and a receive-event code showing activity. The bus is not released.
- R7: A status byte sent with no receive active is followed by one turnaround cycle with `ulpi_dir`=0 and `ulpi_nxt`=0. Then come link cycles with `ulpi_dir`=0 and `ulpi_nxt`=1.
- R8: The turnaround toward the PHY side drives `ulpi_dir`=1 and `ulpi_dout`=0x00, with `ulpi_nxt` equal to `rxs_valid`.
- R9: Link bytes accepted from the first non-zero byte onward appear in order on `txc_data`. `txc_last`=1 is set only on the byte accepted just before the cycle with `ulpi_stp`=1.
- R10: A link cycle with data 0x00, `ulpi_stp`=0 and no packet open is followed by a turnaround toward the PHY side.
- R11: `proto_err` pulses in the cycle after any of these: the link enables its drivers while the PHY side owns the bus or during a turnaround; `ulpi_stp` is high while the PHY side owns the bus; `ulpi_stp` is high with a non-zero data byte.
- R12: After a link cycle with `ulpi_stp`=1, the next cycle is a turnaround with `ulpi_dir`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ulpi_dir | output | 1 | 1 = PHY side owns the data bus |
| ulpi_nxt | output | 1 | Data marker when PHY owns the bus, ready when the link does |
| ulpi_dout | output | 8 | Byte driven by the PHY side |
| ulpi_din | input | 8 | Byte driven by the link |
| ulpi_link_oe | input | 1 | Link output-enable for the data bus |
| ulpi_stp | input | 1 | Link stop strobe |
| rxs_valid | input | 1 | Receive stream byte valid |
| rxs_data | input | 8 | Receive stream byte |
| rxs_last | input | 1 | Final byte of a receive packet |
| rxs_ready | output | 1 | Receive stream byte taken this cycle |
| st_sess_end | input | 1 | Session-end indication |
| st_sess_valid | input | 1 | Session-valid indication |
| st_vbus_valid | input | 1 | VBUS-valid indication |
| st_host_disc | input | 1 | Host disconnect indication |
| st_rx_err | input | 1 | Receive error indication |
| txc_valid | output | 1 | Captured link byte valid (one cycle) |
| txc_data | output | 8 | Captured link byte |
| txc_last | output | 1 | Captured byte ends the packet |
| proto_err | output | 1 | One-cycle bus misuse pulse |

## Verification
The bench checks whether a packet gap mid-receive still reports receive-active. A design that dropped this would show idle status and release the bus with a packet half sent. It checks that a turnaround never carries data. A design that skipped the idle cycle, or drove `nxt` in the wrong sense, would collide with the link's drivers. It checks that the last capture flag lands on the byte before `stp` and not on the NOOP byte. A design without a one-byte hold would mark the wrong byte or forward the NOOP. It also covers each of the four VBUS and event codes, and each misuse case that should pulse the error output.

// File: rtl/ulpi_resp_pkg.sv
package ulpi_resp_pkg;
  localparam int BYTE_W = 8;
  localparam logic [1:0] LINE_J = 2'b01;
  localparam logic [BYTE_W-1:0] TXCMD_NOOP = '0;

  typedef enum logic [1:0] {
    BUS_PHY     = 2'd0,
    BUS_TA_LINK = 2'd1,
    BUS_LINK    = 2'd2,
    BUS_TA_PHY  = 2'd3
  } bus_state_e;

  function automatic logic [1:0] vbus_code(input logic s_end, input logic s_valid,
                                           input logic v_valid);
    if (v_valid)      return 2'b11;
    else if (s_valid) return 2'b10;
    else if (s_end)   return 2'b00;
    else              return 2'b01;
  endfunction

  function automatic logic [1:0] event_code(input logic active, input logic err,
                                            input logic disc);
    if (disc)               return 2'b10;
    else if (active && err) return 2'b11;
    else if (active)        return 2'b01;
    else                    return 2'b00;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(input logic [1:0] vb,
                                                    input logic [1:0] ev);
    return {2'b00, ev, vb, LINE_J};
  endfunction
endpackage

// File: rtl/ulpi_resp_status.sv
module ulpi_resp_status
  import ulpi_resp_pkg::*;
(
  input  logic              sess_end,
  input  logic              sess_valid,
  input  logic              vbus_valid,
  input  logic              host_disc,
  input  logic              rx_err,
  input  logic              rx_active,
  output logic [BYTE_W-1:0] status_byte
);
  logic [1:0] vb;
  logic [1:0] ev;

  always_comb begin
    vb          = vbus_code(sess_end, sess_valid, vbus_valid);
    ev          = event_code(rx_active, rx_err, host_disc);
    status_byte = pack_status(vb, ev);
  end
endmodule

// File: rtl/ulpi_resp_capture.sv
module ulpi_resp_capture
  import ulpi_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_cycle,
  input  logic [BYTE_W-1:0] din,
  input  logic              stp,
  output logic              link_end,
  output logic              cap_valid,
  output logic [BYTE_W-1:0] cap_data,
  output logic              cap_last
);
  logic              hold_v;
  logic [BYTE_W-1:0] hold_d;

  assign link_end = link_cycle && (stp || (!hold_v && din == TXCMD_NOOP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_d    <= '0;
      cap_valid <= 1'b0;
      cap_data  <= '0;
      cap_last  <= 1'b0;
    end else begin
      cap_valid <= 1'b0;
      cap_last  <= 1'b0;
      if (link_cycle) begin
        if (stp) begin
          if (hold_v) begin
            cap_valid <= 1'b1;
            cap_data  <= hold_d;
            cap_last  <= 1'b1;
          end
          hold_v <= 1'b0;
        end else if (hold_v) begin
          cap_valid <= 1'b1;
          cap_data  <= hold_d;
          hold_d    <= din;
        end else if (din != TXCMD_NOOP) begin
          hold_v <= 1'b1;
          hold_d <= din;
        end
      end
    end
  end
endmodule

// File: rtl/ulpi_resp_busctl.sv
module ulpi_resp_busctl
  import ulpi_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxs_valid,
  input  logic [BYTE_W-1:0] rxs_data,
  input  logic              rxs_last,
  input  logic              link_oe,
  input  logic              stp,
  input  logic [BYTE_W-1:0] din,
  input  logic              link_end,
  input  logic [BYTE_W-1:0] status_byte,
  output logic              dir,
  output logic              nxt,
  output logic [BYTE_W-1:0] dout,
  output logic              rxs_ready,
  output logic              rx_active,
  output bus_state_e        state,
  output logic              proto_err
);
  bus_state_e st_q, st_n;
  logic       in_pkt_q;
  logic       pend_q;
  logic       err_n;

  assign state     = st_q;
  assign rx_active = in_pkt_q || pend_q;

  always_comb begin
    st_n      = st_q;
    dir       = (st_q == BUS_PHY) || (st_q == BUS_TA_PHY);
    nxt       = 1'b0;
    dout      = '0;
    rxs_ready = 1'b0;
    unique case (st_q)
      BUS_PHY: begin
        if (rxs_valid) begin
          nxt       = 1'b1;
          dout      = rxs_data;
          rxs_ready = 1'b1;
        end else begin
          dout = status_byte;
          if (!rx_active) st_n = BUS_TA_LINK;
        end
      end
      BUS_TA_LINK: st_n = BUS_LINK;
      BUS_LINK: begin
        nxt = 1'b1;
        if (link_end) st_n = BUS_TA_PHY;
      end
      BUS_TA_PHY: begin
        nxt  = rxs_valid;
        st_n = BUS_PHY;
      end
      default: st_n = BUS_PHY;
    endcase
  end

  always_comb begin
    err_n = 1'b0;
    if (st_q == BUS_PHY && (link_oe || stp)) err_n = 1'b1;
    if ((st_q == BUS_TA_LINK || st_q == BUS_TA_PHY) && link_oe) err_n = 1'b1;
    if (st_q == BUS_LINK && stp && din != TXCMD_NOOP) err_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= BUS_PHY;
      in_pkt_q  <= 1'b0;
      pend_q    <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      st_q      <= st_n;
      proto_err <= err_n;
      pend_q    <= (st_q == BUS_TA_PHY) && rxs_valid;
      if (rxs_ready) in_pkt_q <= !rxs_last;
    end
  end
endmodule

// File: rtl/ulpi_phy_responder.sv
module ulpi_phy_responder
  import ulpi_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic              ulpi_dir,
  output logic              ulpi_nxt,
  output logic [BYTE_W-1:0] ulpi_dout,
  input  logic [BYTE_W-1:0] ulpi_din,
  input  logic              ulpi_link_oe,
  input  logic              ulpi_stp,
  input  logic              rxs_valid,
  input  logic [BYTE_W-1:0] rxs_data,
  input  logic              rxs_last,
  output logic              rxs_ready,
  input  logic              st_sess_end,
  input  logic              st_sess_valid,
  input  logic              st_vbus_valid,
  input  logic              st_host_disc,
  input  logic              st_rx_err,
  output logic              txc_valid,
  output logic [BYTE_W-1:0] txc_data,
  output logic              txc_last,
  output logic              proto_err
);
  logic [BYTE_W-1:0] status_byte;
  logic              rx_active;
  logic              link_end;
  bus_state_e        state;
  logic              link_cycle;
  logic              ta_cycle;

  assign link_cycle = (state == BUS_LINK);
  assign ta_cycle   = (state == BUS_TA_LINK) || (state == BUS_TA_PHY);

  ulpi_resp_status u_status (
    .sess_end   (st_sess_end),
    .sess_valid (st_sess_valid),
    .vbus_valid (st_vbus_valid),
    .host_disc  (st_host_disc),
    .rx_err     (st_rx_err),
    .rx_active  (rx_active),
    .status_byte(status_byte)
  );

  ulpi_resp_busctl u_busctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxs_valid  (rxs_valid),
    .rxs_data   (rxs_data),
    .rxs_last   (rxs_last),
    .link_oe    (ulpi_link_oe),
    .stp        (ulpi_stp),
    .din        (ulpi_din),
    .link_end   (link_end),
    .status_byte(status_byte),
    .dir        (ulpi_dir),
    .nxt        (ulpi_nxt),
    .dout       (ulpi_dout),
    .rxs_ready  (rxs_ready),
    .rx_active  (rx_active),
    .state      (state),
    .proto_err  (proto_err)
  );

  ulpi_resp_capture u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_cycle(link_cycle),
    .din       (ulpi_din),
    .stp       (ulpi_stp),
    .link_end  (link_end),
    .cap_valid (txc_valid),
    .cap_data  (txc_data),
    .cap_last  (txc_last)
  );
endmodule

// File: rtl/ulpi_resp_chk.sv
module ulpi_resp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dir,
  input logic       nxt,
  input logic [7:0] dout,
  input logic       rxs_valid,
  input logic [7:0] rxs_data,
  input logic       rxs_ready,
  input logic       stp,
  input logic       proto_err,
  input logic       txc_valid,
  input logic       txc_last,
  input logic       ta_cycle
);
  // R5
  rdy_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxs_ready |-> (dir && nxt && dout == rxs_data));

  // R8
  ta_phy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir) |-> (nxt == rxs_valid && dout == 8'h00));

  // R7
  ta_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dir) |-> !nxt);

  // R2
  status_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && !nxt && !ta_cycle) |-> (dout[1:0] == 2'b01 && dout[7:6] == 2'b00));

  // R11
  stp_phy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && !ta_cycle && stp) |=> proto_err);

  // R9
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txc_last |-> txc_valid);
endmodule

bind ulpi_phy_responder ulpi_resp_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dir      (ulpi_dir),
  .nxt      (ulpi_nxt),
  .dout     (ulpi_dout),
  .rxs_valid(rxs_valid),
  .rxs_data (rxs_data),
  .rxs_ready(rxs_ready),
  .stp      (ulpi_stp),
  .proto_err(proto_err),
  .txc_valid(txc_valid),
  .txc_last (txc_last),
  .ta_cycle (ta_cycle)
);

// File: tb/sim_ulpi_phy_responder.sv
module sim_ulpi_phy_responder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ulpi_dir, ulpi_nxt;
  logic [7:0] ulpi_dout;
  logic [7:0] ulpi_din = 8'h00;
  logic       ulpi_link_oe = 1'b0, ulpi_stp = 1'b0;
  logic       rxs_valid = 1'b0, rxs_last = 1'b0, rxs_ready;
  logic [7:0] rxs_data = 8'h00;
  logic       st_sess_end = 1'b1, st_sess_valid = 1'b0, st_vbus_valid = 1'b0;
  logic       st_host_disc = 1'b0, st_rx_err = 1'b0;
  logic       txc_valid, txc_last, proto_err;
  logic [7:0] txc_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [7:0] cap_d [16];
  logic       cap_l [16];
  int         cap_n = 0;

  always #4 clk = ~clk;

  ulpi_phy_responder u0 (.*);

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && txc_valid && cap_n < 16) begin
      cap_d[cap_n] = txc_data;
      cap_l[cap_n] = txc_last;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected status byte, restated from the requirement text
  function automatic logic [7:0] exp_status(input logic se, input logic sv, input logic vv,
                                            input logic act, input logic er, input logic dc);
    logic [1:0] vb, ev;
    case ({vv, sv, se})
      3'b000: vb = 2'b01;
      3'b001: vb = 2'b00;
      3'b010, 3'b011: vb = 2'b10;
      default: vb = 2'b11;
    endcase
    ev = dc ? 2'b10 : (!act ? 2'b00 : (er ? 2'b11 : 2'b01));
    return (8'(ev) << 4) | (8'(vb) << 2) | 8'h01;
  endfunction

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    ulpi_link_oe = 1'b0; ulpi_stp = 1'b0; ulpi_din = 8'h00;
  endtask

  // returns inside a link-owned cycle, before its clock edge
  task automatic go_link();
    for (int i = 0; i < 20; i++) begin
      nx(); idle_inputs(); rxs_valid = 1'b0; #1;
      if (!ulpi_dir && ulpi_nxt) return;
    end
    chk("go_link timeout", 0, 1);
  endtask

  // returns inside a status-byte cycle
  task automatic go_status();
    for (int i = 0; i < 20; i++) begin
      nx(); idle_inputs(); #1;
      if (ulpi_dir && !ulpi_nxt && ulpi_dout != 8'h00) return;
    end
    chk("go_status timeout", 0, 1);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 dir in reset", ulpi_dir, 1);
    nx(); rst_n = 1'b1; #1;
    chk("R1 nxt after reset", ulpi_nxt, 0);
    chk("R1 status after reset", ulpi_dout, exp_status(1, 0, 0, 0, 0, 0));
    chk("R1 ready after reset", rxs_ready, 0);
    chk("R1 err after reset", proto_err, 0);
    nx(); #1;
    chk("R7 turnaround dir", ulpi_dir, 0);
    chk("R7 turnaround nxt", ulpi_nxt, 0);
    nx(); #1;
    chk("R7 link nxt", {ulpi_dir, ulpi_nxt}, 2'b01);
    ulpi_link_oe = 1'b1; ulpi_din = 8'h00;
    nx(); idle_inputs(); #1;
    chk("R10 idle noop returns", ulpi_dir, 1);
    chk("R8 ta data", ulpi_dout, 0);
    chk("R8 ta nxt", ulpi_nxt, 0);
  endtask

  task automatic t_vbus();
    logic [2:0] combos [4] = '{3'b001, 3'b000, 3'b010, 3'b110};
    for (int k = 0; k < 4; k++) begin
      {st_vbus_valid, st_sess_valid, st_sess_end} = combos[k];
      go_status();
      chk($sformatf("R3 R2 vbus combo %0d", k), ulpi_dout,
          exp_status(st_sess_end, st_sess_valid, st_vbus_valid, 0, 0, 0));
    end
    st_host_disc = 1'b1;
    go_status();
    chk("R4 host disconnect", ulpi_dout,
        exp_status(st_sess_end, st_sess_valid, st_vbus_valid, 0, 0, 1));
    st_host_disc = 1'b0;
  endtask

  task automatic t_rx();
    logic [7:0] pk [3] = '{8'hC3, 8'h5A, 8'h7E};
    go_link();
    ulpi_link_oe = 1'b1; ulpi_din = 8'h00;
    rxs_valid = 1'b1; rxs_data = pk[0]; rxs_last = 1'b0;
    nx(); idle_inputs(); #1;
    chk("R8 ta nxt pending", {ulpi_dir, ulpi_nxt}, 2'b11);
    chk("R8 ta no ready", rxs_ready, 0);
    nx(); #1;
    chk("R5 byte0", {ulpi_nxt, rxs_ready, ulpi_dout}, {2'b11, pk[0]});
    nx(); rxs_data = pk[1]; #1;
    chk("R5 byte1", {ulpi_nxt, rxs_ready, ulpi_dout}, {2'b11, pk[1]});
    nx(); rxs_valid = 1'b0; #1;
    chk("R6 gap active", {ulpi_dir, ulpi_nxt, ulpi_dout}, {2'b10, exp_status(st_sess_end, st_sess_valid, st_vbus_valid, 1, 0, 0)});
    nx(); st_rx_err = 1'b1; #1;
    chk("R4 R6 gap error", {ulpi_dir, ulpi_dout}, {1'b1, exp_status(st_sess_end, st_sess_valid, st_vbus_valid, 1, 1, 0)});
    nx(); st_rx_err = 1'b0; rxs_valid = 1'b1; rxs_data = pk[2]; rxs_last = 1'b1; #1;
    chk("R5 last byte", {ulpi_nxt, rxs_ready, ulpi_dout}, {2'b11, pk[2]});
    nx(); rxs_valid = 1'b0; rxs_last = 1'b0; #1;
    chk("R7 R4 idle status", {ulpi_dir, ulpi_nxt, ulpi_dout}, {2'b10, exp_status(st_sess_end, st_sess_valid, st_vbus_valid, 0, 0, 0)});
    nx(); #1;
    chk("R7 release turnaround", {ulpi_dir, ulpi_nxt}, 2'b00);
  endtask

  task automatic t_tx();
    cap_n = 0;
    go_link();
    ulpi_link_oe = 1'b1; ulpi_din = 8'h41;
    nx(); ulpi_din = 8'hAA; #1;
    chk("R9 link ready", {ulpi_dir, ulpi_nxt}, 2'b01);
    nx(); ulpi_din = 8'h00; #1;
    nx(); ulpi_din = 8'h00; ulpi_stp = 1'b1; #1;
    chk("R9 still link at stp", {ulpi_dir, ulpi_nxt}, 2'b01);
    nx(); idle_inputs(); #1;
    chk("R12 ta after stp", {ulpi_dir, ulpi_nxt, ulpi_dout}, {2'b10, 8'h00});
    nx(); #1;
    chk("R9 capture count", cap_n, 3);
    chk("R9 cap0", {cap_d[0], cap_l[0]}, {8'h41, 1'b0});
    chk("R9 cap1", {cap_d[1], cap_l[1]}, {8'hAA, 1'b0});
    chk("R9 cap2 last", {cap_d[2], cap_l[2]}, {8'h00, 1'b1});
    chk("R11 no err clean tx", proto_err, 0);
  endtask

  task automatic t_err();
    go_status();
    ulpi_link_oe = 1'b1;
    nx(); idle_inputs(); #1;
    chk("R11 oe while phy owns", proto_err, 1);
    go_status();
    ulpi_stp = 1'b1;
    nx(); idle_inputs(); #1;
    chk("R11 stp while phy owns", proto_err, 1);
    nx(); #1;
    chk("R11 pulse clears", proto_err, 0);
    go_link();
    ulpi_link_oe = 1'b1; ulpi_din = 8'h42;
    nx(); ulpi_din = 8'h12; ulpi_stp = 1'b1; #1;
    nx(); idle_inputs(); #1;
    chk("R11 stp with data", proto_err, 1);
    chk("R11 oe in turnaround clean", ulpi_dir, 1);
    ulpi_link_oe = 1'b1;
    nx(); idle_inputs(); #1;
    chk("R11 oe during turnaround", proto_err, 1);
  endtask

  initial begin
    t_reset();
    t_vbus();
    t_rx();
    t_tx();
    t_err();
    nx(); nx();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_fail = n_fail + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule